// File: doc/BRIEF.md
# Bus Clock Source Switch Sequencer

This block changes the clock that feeds a two-channel ATA bus engine. The clock can come from a local PLL or from the host bus clock. A switch is never a bare change of a multiplexer select. The sequencer first parks both channels off the bus. It then moves the select code and holds the channel logic in reset. While the reset is held, it pulses a read-modify-write of each channel's control byte, which sets the protocol state-machine reset bits and keeps every other bit as it was. It then releases the channel reset and, as the very last step, reconnects the channels to the bus. Each step lasts a fixed minimum number of cycles so that the new clock can settle.

A request carries the wanted source code. The sequencer acts on it only when the code is legal and differs from the source currently selected. While a switch is running, the sequencer raises busy and drops any further request. A small policy helper computes which source a transfer needs: the PLL for a write or for a fast host bus, and the host bus clock otherwise. The upstream logic can use that result as the request code.

Top module: `clksw_seq`

## Requirements
- R1: After reset, both tristate enables are 0, the select code is 0x21 (PLL), the channel reset is 2'b00, and busy, done and all control-byte write strobes are 0.
- R2: A request with code 0x21 (PLL) or 0x23 (host bus) that differs from the current select sets every tristate enable and busy in the cycle after it is taken. The select code keeps its old value for STEP_CYC cycles of isolation and only then takes the new code.
- R3: The channel reset goes to 2'b11 on the same edge that changes the select code, and it stays there for 2*STEP_CYC cycles.
- R4: STEP_CYC cycles after the select change, each channel's write strobe is high for exactly one cycle. Its data is the control byte sampled on that edge ORed with 0x32. Bit 2 (the channel enable) and every other bit outside 0x32 pass through unchanged.
- R5: The channel reset returns to 2'b00 STEP_CYC cycles after the write strobe. The tristate enables return to 0 STEP_CYC cycles after that, so reconnection is the final step.
- R6: Done is high for exactly one cycle, in the cycle in which the tristate enables return to 0. Busy drops in that same cycle.
- R7: A request whose code equals the current select code has no effect on any output.
- R8: A request whose code is neither 0x21 nor 0x23 has no effect on any output.
- R9: A request that arrives while busy is high is dropped. The running switch ends on its own target code, and no second switch follows.
- R10: The policy code is 0x21 when the transfer is a write or the host bus is fast, and 0x23 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Switch request strobe |
| req_code | input | 8 | Wanted source code (0x21 PLL, 0x23 host bus) |
| chan_ctrl | input | NCH*8 | Present control byte of each channel, channel 0 in the low byte |
| pol_write | input | 1 | Policy input: the transfer writes to the device |
| pol_host_fast | input | 1 | Policy input: the host bus runs at the fast rate |
| pol_code | output | 8 | Source code that the policy requires |
| bus_tri | output | NCH | Per-channel bus isolation, 1 = tristated |
| clk_sel | output | 8 | Clock select code driven to the multiplexer |
| chan_rst | output | 2 | Channel logic reset pattern |
| smr_wr_en | output | NCH | Per-channel one-cycle control-byte write strobe |
| smr_wr_data | output | NCH*8 | Per-channel control byte with the state-machine reset bits set |
| busy | output | 1 | A switch is in progress |
| done | output | 1 | One-cycle pulse on reconnection |

## Verification
The bench builds the sequencer with STEP_CYC = 3 and two channels. A step length of 3 is not a power of two, so an off-by-one in the step counter's wrap shows up as a shifted edge. Every output is checked cycle by cycle across the whole 4*STEP_CYC-cycle switch. The two channels get different control bytes, one with the enable bit set and one without, so the check of bit-2 preservation can tell the channels apart. A second request injected in the middle of a switch and a later return to the PLL show that a dropped request leaves the running switch unchanged and starts nothing afterwards.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int          CODE_W      = 8;
    localparam int          CRST_W      = 2;
    localparam logic [7:0]  CODE_PLL    = 8'h21;
    localparam logic [7:0]  CODE_HOST   = 8'h23;
    localparam logic [7:0]  SMR_BITS    = 8'h32;
    localparam logic [1:0]  CRST_ON     = 2'b11;
    localparam logic [1:0]  CRST_OFF    = 2'b00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISOLATE,
        ST_SELECT,
        ST_SMRST,
        ST_RELEASE
    } seq_state_e;

    function automatic logic code_legal(input logic [CODE_W-1:0] code);
        return (code == CODE_PLL) || (code == CODE_HOST);
    endfunction

    function automatic logic [CODE_W-1:0] pick_code(input logic wr, input logic fast);
        return (wr || fast) ? CODE_PLL : CODE_HOST;
    endfunction

endpackage

// File: rtl/clksw_policy.sv
module clksw_policy
    import clksw_pkg::*;
(
    input  logic              op_write,
    input  logic              host_fast,
    output logic [CODE_W-1:0] need_code
);

    always_comb begin
        need_code = pick_code(op_write, host_fast);
    end

endmodule

// File: rtl/clksw_step_timer.sv
module clksw_step_timer #(
    parameter int STEP_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);

    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt_q;

    assign last = run && (cnt_q == LAST_VAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_VAL); // R2

endmodule

// File: rtl/clksw_ctl_rmw.sv
module clksw_ctl_rmw
    import clksw_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [NCH*8-1:0] ctrl_in,
    output logic [NCH-1:0]   wr_en,
    output logic [NCH*8-1:0] wr_data
);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic       en_q;
        logic [7:0] dat_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q  <= 1'b0;
                dat_q <= '0;
            end else begin
                en_q <= fire;
                if (fire) begin
                    dat_q <= ctrl_in[c*8 +: 8] | SMR_BITS;
                end
            end
        end

        assign wr_en[c]          = en_q;
        assign wr_data[c*8 +: 8] = dat_q;

        AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            en_q |=> !en_q); // R4
    end

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int STEP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [7:0]        req_code,
    input  logic [NCH*8-1:0]  chan_ctrl,
    input  logic              pol_write,
    input  logic              pol_host_fast,
    output logic [7:0]        pol_code,
    output logic [NCH-1:0]    bus_tri,
    output logic [7:0]        clk_sel,
    output logic [1:0]        chan_rst,
    output logic [NCH-1:0]    smr_wr_en,
    output logic [NCH*8-1:0]  smr_wr_data,
    output logic              busy,
    output logic              done
);

    seq_state_e        state_q;
    logic [NCH-1:0]    tri_q;
    logic [CODE_W-1:0] sel_q;
    logic [CODE_W-1:0] pend_q;
    logic [CRST_W-1:0] crst_q;
    logic              done_q;
    logic              step_last;
    logic              accept;
    logic              smr_fire;

    clksw_policy u_policy (
        .op_write  (pol_write),
        .host_fast (pol_host_fast),
        .need_code (pol_code)
    );

    clksw_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q != ST_IDLE),
        .last (step_last)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid &&
                      code_legal(req_code) && (req_code != sel_q);
    assign smr_fire = (state_q == ST_SELECT) && step_last;

    clksw_ctl_rmw #(.NCH(NCH)) u_rmw (
        .clk     (clk),
        .rst     (rst),
        .fire    (smr_fire),
        .ctrl_in (chan_ctrl),
        .wr_en   (smr_wr_en),
        .wr_data (smr_wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tri_q   <= '0;
            sel_q   <= CODE_PLL;
            pend_q  <= CODE_PLL;
            crst_q  <= CRST_OFF;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_ISOLATE;
                        tri_q   <= '1;
                        pend_q  <= req_code;
                    end
                end
                ST_ISOLATE: begin
                    if (step_last) begin
                        state_q <= ST_SELECT;
                        sel_q   <= pend_q;
                        crst_q  <= CRST_ON;
                    end
                end
                ST_SELECT: begin
                    if (step_last) begin
                        state_q <= ST_SMRST;
                    end
                end
                ST_SMRST: begin
                    if (step_last) begin
                        state_q <= ST_RELEASE;
                        crst_q  <= CRST_OFF;
                    end
                end
                ST_RELEASE: begin
                    if (step_last) begin
                        state_q <= ST_IDLE;
                        tri_q   <= '0;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_tri  = tri_q;
    assign clk_sel  = sel_q;
    assign chan_rst = crst_q;
    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;

    AST_ISO_BEFORE_SEL: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> (&tri_q) && (&$past(tri_q))); // R2

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        code_legal(sel_q)); // R2

    AST_SEL_WITH_RST: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> (crst_q == CRST_ON)); // R3

    AST_STROBE_IN_RST: assert property (@(posedge clk) disable iff (rst)
        (|smr_wr_en) |-> (crst_q == CRST_ON) && (&tri_q)); // R4

    AST_RECONNECT_LAST: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (crst_q == CRST_OFF) && ($past(crst_q) == CRST_OFF) &&
                   (&$past(tri_q)) && !(|tri_q)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R6

    AST_BUSY_HOLDS_TARGET: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) && req_valid |=> $stable(pend_q)); // R9

endmodule

// File: tb/clksw_seq_test.sv
module clksw_seq_test;

    localparam int NCH = 2;
    localparam int S   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [7:0]        req_code = 8'h00;
    logic [NCH*8-1:0]  chan_ctrl = '0;
    logic              pol_write = 1'b0;
    logic              pol_host_fast = 1'b0;
    logic [7:0]        pol_code;
    logic [NCH-1:0]    bus_tri;
    logic [7:0]        clk_sel;
    logic [1:0]        chan_rst;
    logic [NCH-1:0]    smr_wr_en;
    logic [NCH*8-1:0]  smr_wr_data;
    logic              busy;
    logic              done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    clksw_seq #(.NCH(NCH), .STEP_CYC(S)) uut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_code      (req_code),
        .chan_ctrl     (chan_ctrl),
        .pol_write     (pol_write),
        .pol_host_fast (pol_host_fast),
        .pol_code      (pol_code),
        .bus_tri       (bus_tri),
        .clk_sel       (clk_sel),
        .chan_rst      (chan_rst),
        .smr_wr_en     (smr_wr_en),
        .smr_wr_data   (smr_wr_data),
        .busy          (busy),
        .done          (done)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Idle observation: nothing moves for n cycles (R7, R8 style checks)
    task automatic watch_idle(input string req, input logic [7:0] sel, input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(req, {28'd0, busy, done, bus_tri}, 32'd0);
            check(req, {24'd0, clk_sel}, {24'd0, sel});
            check(req, {28'd0, chan_rst, smr_wr_en}, 32'd0);
        end
    endtask

    // Full switch with per-cycle checks. inject: drop a second request mid-switch (R9)
    task automatic run_switch(input logic [7:0] old_code, input logic [7:0] new_code,
                              input logic [15:0] ctrl, input logic inject);
        @(negedge clk);
        chan_ctrl = ctrl;
        req_code  = new_code;
        req_valid = 1'b1;
        for (int i = 0; i <= 4*S; i++) begin
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            if (inject && i == S + 1) begin
                req_valid = 1'b1;
                req_code  = old_code;
            end
            check("R2 tristate", {30'd0, bus_tri}, (i < 4*S) ? 32'd3 : 32'd0);
            check("R2 busy", {31'd0, busy}, (i < 4*S) ? 32'd1 : 32'd0);
            check("R2 select", {24'd0, clk_sel}, {24'd0, (i >= S) ? new_code : old_code});
            check("R3 chan_rst", {30'd0, chan_rst}, (i >= S && i < 3*S) ? 32'd3 : 32'd0);
            check("R4 strobe", {30'd0, smr_wr_en}, (i == 2*S) ? 32'd3 : 32'd0);
            if (i == 2*S) begin
                check("R4 data ch0", {24'd0, smr_wr_data[7:0]}, {24'd0, ctrl[7:0] | 8'h32});
                check("R4 data ch1", {24'd0, smr_wr_data[15:8]}, {24'd0, ctrl[15:8] | 8'h32});
                check("R4 enable bit ch0", {31'd0, smr_wr_data[2]}, {31'd0, ctrl[2]});
                check("R4 enable bit ch1", {31'd0, smr_wr_data[10]}, {31'd0, ctrl[10]});
            end
            check("R5 R6 done", {31'd0, done}, (i == 4*S) ? 32'd1 : 32'd0);
        end
        req_valid = 1'b0;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 tristate", {30'd0, bus_tri}, 32'd0);
        check("R1 select", {24'd0, clk_sel}, 32'h21);
        check("R1 chan_rst", {30'd0, chan_rst}, 32'd0);
        check("R1 busy done", {30'd0, busy, done}, 32'd0);
        check("R1 strobe", {30'd0, smr_wr_en}, 32'd0);
    endtask

    task automatic test_same_code(input logic [7:0] cur);
        @(negedge clk);
        req_code  = cur;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 same code ignored", {31'd0, busy}, 32'd0);
        watch_idle("R7 same code ignored", cur, 2*S);
    endtask

    task automatic test_bad_code(input logic [7:0] cur);
        @(negedge clk);
        req_code  = 8'h55;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_code  = 8'h22;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 illegal code ignored", {31'd0, busy}, 32'd0);
        watch_idle("R8 illegal code ignored", cur, 2*S);
    endtask

    task automatic test_policy();
        for (int k = 0; k < 4; k++) begin
            pol_write     = k[0];
            pol_host_fast = k[1];
            #1;
            check("R10 policy", {24'd0, pol_code}, (k == 0) ? 32'h23 : 32'h21);
        end
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_policy();
        // PLL -> host: ch0 enabled (bit 2), ch1 disabled
        run_switch(8'h21, 8'h23, 16'h0004 | 16'h8100, 1'b0);
        test_same_code(8'h23);
        test_bad_code(8'h23);
        // host -> PLL with a request dropped mid-switch (R9)
        run_switch(8'h23, 8'h21, 16'hFF40, 1'b1);
        watch_idle("R9 no follow-up switch", 8'h21, 2*S);
        // PLL -> host again with all-zero control bytes
        run_switch(8'h21, 8'h23, 16'h0000, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule